// File: doc/BRIEF.md
# CCD Line and Field Timing Generator

This block runs the readout timing of an interline colour CCD from one pixel clock. A pixel counter steps through every clock of a horizontal line. A line counter steps once per line and wraps at the end of a field. For each sample the block emits a horizontal and a vertical region code, a combined active-pixel flag, and one-clock line and field sync strobes. It also emits a window inside horizontal blanking that is set aside for vertical charge transfer, and two colour-phase bits that follow the two-row G/B and R/G mosaic.

The parameter `CLK_PLAN` selects the clock plan. Plan 0 is the 14.32 MHz plan and plan 1 is the 18.00 MHz plan. The plan sets the line length and the length of the transfer window. Each region count is a parameter, so a downstream clamp, a line buffer or a colour pipeline can be fed directly from the region codes and the phase bits.

All outputs come from one register stage. The pixel and line indices on the ports therefore describe the same sample as the flags on the same cycle.

Top module: `ccd_timing_gen`

## Requirements
- R1: `pix_idx` steps by one each clock from 0 up to LINE−1 and then wraps to 0. LINE is 1316 for `CLK_PLAN`=0 and 1336 for `CLK_PLAN`=1.
- R2: `h_region` is coded 1 = dummy, 2 = front black, 3 = active, 4 = rear black, 0 = blank. With default counts, pixel indices 0–21 are code 1, 22–24 are code 2, 25–1198 are code 3, 1199–1238 are code 4, and 1239 up to LINE−1 are code 0.
- R3: `line_idx` advances when `pix_idx` wraps and returns to 0 after the last line of the field. `v_region` uses the same codes as `h_region`, in this order: V_DUMMY dummy lines, V_FOB front black lines (7 by default), V_ACT active lines (884 by default), V_ROB rear black lines (2 by default), then V_BLANK blank lines.
- R4: `pix_valid` is high exactly when both `h_region` and `v_region` are 3. It is low on every blank sample.
- R5: `hsync` is high for one clock, on the sample where `pix_idx` is 0. `vsync` is high only on the sample where `pix_idx` is 0 and `line_idx` is 0.
- R6: `xfer_win` is high for 72 clocks (plan 0) or 90 clocks (plan 1), starting at pixel index 1239. It lies entirely within horizontal blanking.
- R7: `row_phase` equals bit 0 of `line_idx`, where 0 is a G/B row. `pix_phase` is 0 outside the horizontal active region. Inside it, `pix_phase` starts at `row_phase` on the first active pixel and toggles on every following active pixel.
- R8: `rst` is synchronous and active high. While it is held, both indices are 0 and every code, strobe, flag and phase output is 0. The first sample after release has index 0 on both axes, with `hsync` and `vsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_idx | output | H_W | Pixel index within the line |
| line_idx | output | V_W | Line index within the field |
| hsync | output | 1 | Line start strobe |
| vsync | output | 1 | Field start strobe |
| h_region | output | 3 | Horizontal region code |
| v_region | output | 3 | Vertical region code |
| pix_valid | output | 1 | Sample is active on both axes |
| xfer_win | output | 1 | Vertical transfer window within horizontal blanking |
| row_phase | output | 1 | Mosaic row type of the line |
| pix_phase | output | 1 | Mosaic column phase of the active pixel |

## Verification
The bench builds two instances at once, one for each clock plan. Both keep the full horizontal counts, so every pixel of every line is compared against bench arithmetic, and the region tallies of each line are checked against 22/3/1174/40. The vertical counts are cut to 1 dummy, 2 front black, 4 active, 1 rear black and 2 blank lines. That makes a field 10 lines long, so whole fields, field wrap and line-parity phase can be reached within the run. A reset applied mid-line then confirms that the outputs clear and that timing restarts at index 0.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [2:0] {
    RG_BLANK = 3'd0,
    RG_DUMMY = 3'd1,
    RG_FOB   = 3'd2,
    RG_ACT   = 3'd3,
    RG_ROB   = 3'd4
  } region_e;

  // clocks per horizontal line for each clock plan
  function automatic int unsigned plan_line_len(int unsigned plan);
    return (plan == 0) ? 1316 : 1336;
  endfunction

  // clocks reserved for vertical transfer inside horizontal blanking
  function automatic int unsigned plan_xfer_len(int unsigned plan);
    return (plan == 0) ? 72 : 90;
  endfunction

  // region of an index along one axis, given the run lengths in readout order
  function automatic region_e classify(int unsigned idx, int unsigned n_dummy,
                                       int unsigned n_fob, int unsigned n_act,
                                       int unsigned n_rob);
    int unsigned edge_fob, edge_act, edge_rob, edge_end;
    edge_fob = n_dummy;
    edge_act = edge_fob + n_fob;
    edge_rob = edge_act + n_act;
    edge_end = edge_rob + n_rob;
    if (idx < edge_fob)      return RG_DUMMY;
    else if (idx < edge_act) return RG_FOB;
    else if (idx < edge_rob) return RG_ACT;
    else if (idx < edge_end) return RG_ROB;
    else                     return RG_BLANK;
  endfunction

endpackage

// File: rtl/ccd_tg_counter.sv
module ccd_tg_counter #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] cnt,
  output logic         at_first,
  output logic         at_last
);

  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  assign at_last  = (cnt == LAST);
  assign at_first = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (adv)   cnt <= at_last ? '0 : cnt + 1'b1;
  end

  // R1 / R3: counting behaviour
  a_r1_r3_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !at_last) |=> (cnt == $past(cnt) + 1'b1));
  a_r1_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && at_last) |=> (cnt == '0));
  a_r1_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/ccd_tg_axis.sv
module ccd_tg_axis
  import ccd_tg_pkg::*;
#(
  parameter int unsigned N_DUMMY = 1,
  parameter int unsigned N_FOB   = 1,
  parameter int unsigned N_ACT   = 1,
  parameter int unsigned N_ROB   = 1,
  parameter int unsigned W       = 4
) (
  input  logic [W-1:0] idx,
  output region_e      region,
  output logic         in_act
);

  assign region = classify(32'(idx), N_DUMMY, N_FOB, N_ACT, N_ROB);
  assign in_act = (region == RG_ACT);

endmodule

// File: rtl/ccd_tg_phase.sv
module ccd_tg_phase (
  input  logic clk,
  input  logic rst,
  input  logic line_start,
  input  logic line_odd,
  input  logic act_next,
  output logic row_phase,
  output logic pix_phase
);

  logic tog;
  logic act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog       <= 1'b0;
      act_q     <= 1'b0;
      row_phase <= 1'b0;
      pix_phase <= 1'b0;
    end else begin
      if (line_start)    tog <= line_odd;
      else if (act_next) tog <= ~tog;
      act_q     <= act_next;
      row_phase <= line_odd;
      pix_phase <= act_next ? tog : 1'b0;
    end
  end

  // R7: phase alternates across consecutive active pixels, quiet otherwise
  a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
    (act_q && $past(act_q)) |-> (pix_phase != $past(pix_phase)));
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> !pix_phase);

endmodule

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen
  import ccd_tg_pkg::*;
#(
  parameter int unsigned CLK_PLAN = 0,
  parameter int unsigned H_DUMMY  = 22,
  parameter int unsigned H_FOB    = 3,
  parameter int unsigned H_ACT    = 1174,
  parameter int unsigned H_ROB    = 40,
  parameter int unsigned V_DUMMY  = 2,
  parameter int unsigned V_FOB    = 7,
  parameter int unsigned V_ACT    = 884,
  parameter int unsigned V_ROB    = 2,
  parameter int unsigned V_BLANK  = 10,
  parameter int unsigned H_W      = 11,
  parameter int unsigned V_W      = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [H_W-1:0] pix_idx,
  output logic [V_W-1:0] line_idx,
  output logic           hsync,
  output logic           vsync,
  output logic [2:0]     h_region,
  output logic [2:0]     v_region,
  output logic           pix_valid,
  output logic           xfer_win,
  output logic           row_phase,
  output logic           pix_phase
);

  localparam int unsigned LINE_LEN = plan_line_len(CLK_PLAN);
  localparam int unsigned XFER_LEN = plan_xfer_len(CLK_PLAN);
  localparam int unsigned H_DEF    = H_DUMMY + H_FOB + H_ACT + H_ROB;
  localparam int unsigned V_TOTAL  = V_DUMMY + V_FOB + V_ACT + V_ROB + V_BLANK;

  // counter stage
  logic [H_W-1:0] hcnt;
  logic [V_W-1:0] vcnt;
  logic h_first, h_last, v_first, v_last;

  ccd_tg_counter #(.LIMIT(LINE_LEN), .W(H_W)) i_hcnt (
    .clk(clk), .rst(rst), .adv(1'b1),
    .cnt(hcnt), .at_first(h_first), .at_last(h_last)
  );

  ccd_tg_counter #(.LIMIT(V_TOTAL), .W(V_W)) i_vcnt (
    .clk(clk), .rst(rst), .adv(h_last),
    .cnt(vcnt), .at_first(v_first), .at_last(v_last)
  );

  // classification of the counter-stage sample
  region_e h_rg, v_rg;
  logic    h_in_act, v_in_act;

  ccd_tg_axis #(.N_DUMMY(H_DUMMY), .N_FOB(H_FOB), .N_ACT(H_ACT),
                .N_ROB(H_ROB), .W(H_W)) i_haxis (
    .idx(hcnt), .region(h_rg), .in_act(h_in_act)
  );

  ccd_tg_axis #(.N_DUMMY(V_DUMMY), .N_FOB(V_FOB), .N_ACT(V_ACT),
                .N_ROB(V_ROB), .W(V_W)) i_vaxis (
    .idx(vcnt), .region(v_rg), .in_act(v_in_act)
  );

  // named events of the counter stage
  logic field_start;
  logic in_xfer;
  logic both_act;

  assign field_start = h_first && v_first;
  assign in_xfer     = (32'(hcnt) >= H_DEF) && (32'(hcnt) < H_DEF + XFER_LEN);
  assign both_act    = h_in_act && v_in_act;

  ccd_tg_phase i_phase (
    .clk(clk), .rst(rst),
    .line_start(h_first), .line_odd(vcnt[0]), .act_next(h_in_act),
    .row_phase(row_phase), .pix_phase(pix_phase)
  );

  // output register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_idx   <= '0;
      line_idx  <= '0;
      hsync     <= 1'b0;
      vsync     <= 1'b0;
      h_region  <= RG_BLANK;
      v_region  <= RG_BLANK;
      pix_valid <= 1'b0;
      xfer_win  <= 1'b0;
    end else begin
      pix_idx   <= hcnt;
      line_idx  <= vcnt;
      hsync     <= h_first;
      vsync     <= field_start;
      h_region  <= h_rg;
      v_region  <= v_rg;
      pix_valid <= both_act;
      xfer_win  <= in_xfer;
    end
  end

  // R5: strobes
  a_r5_hsync_single: assert property (@(posedge clk) disable iff (rst)
    hsync |=> !hsync);
  a_r5_hsync_at_zero: assert property (@(posedge clk) disable iff (rst)
    hsync |-> (pix_idx == '0));
  a_r5_vsync_in_line0: assert property (@(posedge clk) disable iff (rst)
    vsync |-> (hsync && line_idx == '0));
  // R1: output index follows the counter with wrap
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (pix_idx == H_W'(LINE_LEN - 1)) |=> hsync);
  // R4: valid only on active samples of both axes
  a_r4_valid_needs_act: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (h_region == RG_ACT && v_region == RG_ACT));
  a_r4_blank_quiet: assert property (@(posedge clk) disable iff (rst)
    (h_region == RG_BLANK) |-> !pix_valid);
  // R6: transfer window inside horizontal blanking
  a_r6_xfer_in_blank: assert property (@(posedge clk) disable iff (rst)
    xfer_win |-> (h_region == RG_BLANK));
  // R8: reset clears the output stage
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (!hsync && !vsync && !pix_valid && !xfer_win && h_region == 3'd0));

endmodule

// File: tb/test_ccd_timing_gen.sv
module test_ccd_timing_gen;

  localparam int VD = 1, VF = 2, VA = 4, VR = 1, VB = 2;
  localparam int VTOT = VD + VF + VA + VR + VB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [10:0] pix   [2];
  logic [9:0]  lin   [2];
  logic        hs    [2];
  logic        vs    [2];
  logic [2:0]  hr    [2];
  logic [2:0]  vr    [2];
  logic        pv    [2];
  logic        xw    [2];
  logic        rp    [2];
  logic        pp    [2];

  for (genvar g = 0; g < 2; g++) begin : g_dut
    ccd_timing_gen #(
      .CLK_PLAN(g), .V_DUMMY(VD), .V_FOB(VF), .V_ACT(VA), .V_ROB(VR), .V_BLANK(VB)
    ) i_ccd_timing_gen (
      .clk(clk), .rst(rst),
      .pix_idx(pix[g]), .line_idx(lin[g]), .hsync(hs[g]), .vsync(vs[g]),
      .h_region(hr[g]), .v_region(vr[g]), .pix_valid(pv[g]), .xfer_win(xw[g]),
      .row_phase(rp[g]), .pix_phase(pp[g])
    );
  end

  int checks = 0;
  int errors = 0;
  bit trk = 0;
  bit done = 0;
  int ep [2];
  int el [2];
  int hc [2][5];
  int vc [2][5];
  int xc [2];

  function automatic int line_len(int g);
    return (g == 0) ? 1316 : 1336;
  endfunction
  function automatic int xfer_len(int g);
    return (g == 0) ? 72 : 90;
  endfunction
  function automatic int hcode(int p);
    if (p < 22)        return 1;
    else if (p < 25)   return 2;
    else if (p < 1199) return 3;
    else if (p < 1239) return 4;
    return 0;
  endfunction
  function automatic int vcode(int l);
    if (l < VD)                     return 1;
    else if (l < VD + VF)           return 2;
    else if (l < VD + VF + VA)      return 3;
    else if (l < VD + VF + VA + VR) return 4;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_trackers();
    for (int g = 0; g < 2; g++) begin
      ep[g] = 0;
      el[g] = 0;
      xc[g] = 0;
      for (int k = 0; k < 5; k++) begin
        hc[g][k] = 0;
        vc[g][k] = 0;
      end
    end
  endtask

  task automatic check_reset_state();
    for (int g = 0; g < 2; g++) begin
      chk(pix[g] == 0 && lin[g] == 0, "R8", "indices in reset", int'(pix[g]) + int'(lin[g]), 0);
      chk(!hs[g] && !vs[g] && !pv[g] && !xw[g] && !rp[g] && !pp[g], "R8", "strobes/flags in reset",
          int'(hs[g]) + int'(vs[g]) + int'(pv[g]) + int'(xw[g]) + int'(rp[g]) + int'(pp[g]), 0);
      chk(hr[g] == 0 && vr[g] == 0, "R8", "region codes in reset", int'(hr[g]) + int'(vr[g]), 0);
    end
  endtask

  always @(negedge clk) begin
    if (trk && !done) begin
      for (int g = 0; g < 2; g++) begin
        int p, l, h, v, ph;
        p = ep[g];
        l = el[g];
        h = hcode(p);
        v = vcode(l);
        ph = (h == 3) ? (((p - 25) ^ l) & 1) : 0;
        chk(int'(pix[g]) == p, "R1", "pixel index", int'(pix[g]), p);
        chk(int'(lin[g]) == l, "R3", "line index", int'(lin[g]), l);
        chk(int'(hr[g]) == h, "R2", "h_region", int'(hr[g]), h);
        chk(int'(vr[g]) == v, "R3", "v_region", int'(vr[g]), v);
        chk(pv[g] == (h == 3 && v == 3), "R4", "pix_valid", int'(pv[g]), int'(h == 3 && v == 3));
        chk(hs[g] == (p == 0), "R5", "hsync", int'(hs[g]), int'(p == 0));
        chk(vs[g] == (p == 0 && l == 0), "R5", "vsync", int'(vs[g]), int'(p == 0 && l == 0));
        chk(xw[g] == (p >= 1239 && p < 1239 + xfer_len(g)), "R6", "xfer_win",
            int'(xw[g]), int'(p >= 1239 && p < 1239 + xfer_len(g)));
        chk(int'(rp[g]) == (l & 1), "R7", "row_phase", int'(rp[g]), l & 1);
        chk(int'(pp[g]) == ph, "R7", "pix_phase", int'(pp[g]), ph);
        // tallies
        if (hr[g] < 5) hc[g][hr[g]]++;
        if (xw[g]) xc[g]++;
        if (p == 0 && vr[g] < 5) vc[g][vr[g]]++;
        if (p == line_len(g) - 1) begin
          chk(hc[g][1] == 22, "R2", "dummy per line", hc[g][1], 22);
          chk(hc[g][2] == 3, "R2", "front black per line", hc[g][2], 3);
          chk(hc[g][3] == 1174, "R2", "active per line", hc[g][3], 1174);
          chk(hc[g][4] == 40, "R2", "rear black per line", hc[g][4], 40);
          chk(hc[g][0] == line_len(g) - 1239, "R1", "blank per line", hc[g][0], line_len(g) - 1239);
          chk(xc[g] == xfer_len(g), "R6", "xfer clocks per line", xc[g], xfer_len(g));
          for (int k = 0; k < 5; k++) hc[g][k] = 0;
          xc[g] = 0;
          if (l == VTOT - 1) begin
            chk(vc[g][1] == VD, "R3", "dummy lines", vc[g][1], VD);
            chk(vc[g][2] == VF, "R3", "front black lines", vc[g][2], VF);
            chk(vc[g][3] == VA, "R3", "active lines", vc[g][3], VA);
            chk(vc[g][4] == VR, "R3", "rear black lines", vc[g][4], VR);
            chk(vc[g][0] == VB, "R3", "blank lines", vc[g][0], VB);
            for (int k = 0; k < 5; k++) vc[g][k] = 0;
          end
        end
        // advance expected position
        if (p == line_len(g) - 1) begin
          ep[g] = 0;
          el[g] = (l == VTOT - 1) ? 0 : l + 1;
        end else begin
          ep[g] = p + 1;
        end
      end
    end
  end

  initial begin
    clear_trackers();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    @(posedge clk);
    #1 trk = 1'b1;
    repeat (2 * VTOT * 1336 + 20) @(posedge clk);
    // mid-line reset
    #1 trk = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    clear_trackers();
    @(posedge clk);
    #1 trk = 1'b1;
    repeat (2000) @(posedge clk);
    #1 trk = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule